// File: doc/BRIEF.md
# RS-485 Multidrop Address Receiver

This block sits behind a UART receive core on an RS-485 multidrop bus. Each received character is nine bits wide. In multidrop operation the ninth bit, which normally holds parity, instead marks the character as an address frame. The block chooses which characters go into the receive FIFO. It raises a sticky address-detect interrupt, and it can compare address frames against a station address on its own. With that comparison it turns its own receiver on for a matching address and off for any other address, without software.

Software programs a three-bit control word. Bit 0 enables multidrop operation. Bit 1 disables the receiver. Bit 2 enables automatic address matching. The current control word is visible on an output. The interrupt is cleared by a write-one-to-clear strobe. Every output is registered and changes one clock after the character strobe.

Top module: `rs485_addr_rx`

## Requirements
- R1: After reset the control word (bit 0 multidrop, bit 1 receiver disable, bit 2 auto address) reads 0, the interrupt is low and no FIFO write is issued.
- R2: With multidrop off and the receiver enabled, every valid character is written to the FIFO one cycle after its strobe. The FIFO byte is bits 7:0, bit 8 is ignored and no interrupt is raised.
- R3: With the receiver disabled, data frames (multidrop off, or bit 8 equal to 0) produce no FIFO write.
- R4: With multidrop on and auto address off, every frame with bit 8 equal to 1 is written to the FIFO and sets the interrupt, even while the receiver is disabled. The receiver disable bit is left unchanged.
- R5: A frame with bit 8 equal to 0, or any frame while multidrop is off, never sets the interrupt.
- R6: With multidrop and auto address both on, an address frame whose bits 7:0 equal the station address clears receiver disable. It is written to the FIFO and sets the interrupt.
- R7: With multidrop and auto address both on, an address frame that does not match sets receiver disable. It is not written and does not set the interrupt. Later data frames are dropped until a matching address arrives.
- R8: The interrupt stays set until the clear strobe. A new address event in the same cycle as a clear leaves it set.
- R9: When an automatic match or mismatch falls in the same cycle as a control write, the automatic update of receiver disable wins over the written value.
- R10: Auto address enabled while multidrop is off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| charValid | input | 1 | Strobe: a received character is present |
| charData | input | DATA_W+1 | Received character, bit DATA_W is the address marker |
| stationAddr | input | DATA_W | Station address for automatic matching |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 3 | Control word: bit 0 multidrop, bit 1 receiver disable, bit 2 auto address |
| irqClear | input | 1 | Write-one-to-clear for the interrupt |
| fifoWrite | output | 1 | One-cycle FIFO write strobe |
| fifoData | output | DATA_W | Byte written to the FIFO |
| addrIrq | output | 1 | Sticky address-detect interrupt |
| ctrlState | output | 3 | Current control word |

## Verification
The bench tries every 9-bit character under all eight combinations of multidrop, receiver disable and auto address. These runs show that the marker bit counts only in multidrop mode, and that the disable bit stops data frames but not address frames. They also show that an address frame is accepted or turned away by the station address, and only when both mode bits are on. Directed sequences then check that data is dropped after a mismatch and resumes after a match. They also check the interrupt's hold and clear, and what wins when an automatic update meets a control write or a clear in the same cycle.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  localparam int CTRL_MD  = 0;
  localparam int CTRL_OFF = 1;
  localparam int CTRL_AUTO = 2;
  localparam int CTRL_W   = 3;

  typedef struct packed {
    logic storeChar;
    logic setIrq;
    logic setOff;
    logic clrOff;
  } rxStrobe_t;
endpackage

// File: rtl/rs485_dp.sv
module rs485_dp #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W:0]      charData,
  input  logic [DATA_W-1:0]    stationAddr,
  input  rs485_pkg::rxStrobe_t strb,
  output logic                 addrHit,
  output logic                 fifoWrite,
  output logic [DATA_W-1:0]    fifoData
);
  logic [DATA_W-1:0] bitEq;

  // per-bit equality, reduced below
  for (genvar i = 0; i < DATA_W; i++) begin : gCmp
    assign bitEq[i] = ~(charData[i] ^ stationAddr[i]);
  end
  assign addrHit = &bitEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoWrite <= 1'b0;
      fifoData  <= '0;
    end else begin
      fifoWrite <= strb.storeChar;
      if (strb.storeChar) fifoData <= charData[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/rs485_ctrl.sv
module rs485_ctrl
  import rs485_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic              charMark,
  input  logic              addrHit,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              irqClear,
  output rxStrobe_t         strb,
  output logic [CTRL_W-1:0] ctrlState,
  output logic              addrIrq
);
  logic cfgMd, cfgOff, cfgAuto;
  logic addrFrame;

  assign ctrlState = {cfgAuto, cfgOff, cfgMd};
  assign addrFrame = charValid && cfgMd && charMark;

  always_comb begin
    strb = '0;
    if (addrFrame) begin
      if (cfgAuto) begin
        if (addrHit) begin
          strb.storeChar = 1'b1;
          strb.setIrq    = 1'b1;
          strb.clrOff    = 1'b1;
        end else begin
          strb.setOff = 1'b1;
        end
      end else begin
        strb.storeChar = 1'b1;
        strb.setIrq    = 1'b1;
      end
    end else if (charValid && !cfgOff) begin
      strb.storeChar = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMd   <= 1'b0;
      cfgOff  <= 1'b0;
      cfgAuto <= 1'b0;
      addrIrq <= 1'b0;
    end else begin
      if (ctrlWe) begin
        cfgMd   <= ctrlWdata[CTRL_MD];
        cfgOff  <= ctrlWdata[CTRL_OFF];
        cfgAuto <= ctrlWdata[CTRL_AUTO];
      end
      // automatic update overrides software write
      if (strb.setOff) cfgOff <= 1'b1;
      if (strb.clrOff) cfgOff <= 1'b0;
      if (irqClear) addrIrq <= 1'b0;
      if (strb.setIrq) addrIrq <= 1'b1;
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrIrq) |-> $past(irqClear)); // R8
  AST_NO_DATA_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrIrq) |-> $past(charValid && charMark && cfgMd)); // R5
endmodule

// File: rtl/rs485_addr_rx.sv
module rs485_addr_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W:0]   charData,
  input  logic [DATA_W-1:0] stationAddr,
  input  logic              ctrlWe,
  input  logic [2:0]        ctrlWdata,
  input  logic              irqClear,
  output logic              fifoWrite,
  output logic [DATA_W-1:0] fifoData,
  output logic              addrIrq,
  output logic [2:0]        ctrlState
);
  rs485_pkg::rxStrobe_t strb;
  logic hitW;

  rs485_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charMark(charData[DATA_W]),
    .addrHit(hitW), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .irqClear(irqClear),
    .strb(strb), .ctrlState(ctrlState), .addrIrq(addrIrq)
  );

  rs485_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .charData(charData), .stationAddr(stationAddr),
    .strb(strb), .addrHit(hitW), .fifoWrite(fifoWrite), .fifoData(fifoData)
  );

  AST_DATA_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrite && !($past(charData[DATA_W]) && $past(ctrlState[0])))
      |-> !$past(ctrlState[1])); // R3
  AST_MATCH_ON: assert property (@(posedge clk) disable iff (!rstN)
    $past(charValid && charData[DATA_W] && ctrlState[0] && ctrlState[2] && hitW)
      |-> (!ctrlState[1] && fifoWrite && addrIrq)); // R6
  AST_MISS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(charValid && charData[DATA_W] && ctrlState[0] && ctrlState[2] && !hitW)
      |-> (ctrlState[1] && !fifoWrite)); // R7
endmodule

// File: tb/sim_rs485_addr_rx.sv
`timescale 1ns/1ps
module sim_rs485_addr_rx;
  localparam int DW = 8;
  logic clk = 0, rstN = 0;
  logic charValid = 0, ctrlWe = 0, irqClear = 0;
  logic [DW:0] charData = '0;
  logic [DW-1:0] stationAddr = 8'h5A;
  logic [2:0] ctrlWdata = '0;
  logic fifoWrite, addrIrq;
  logic [DW-1:0] fifoData;
  logic [2:0] ctrlState;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rs485_addr_rx #(.DATA_W(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [2:0] v);
    @(negedge clk); ctrlWe = 1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 0;
  endtask

  task automatic clrIrq();
    @(negedge clk); irqClear = 1;
    @(negedge clk); irqClear = 0;
  endtask

  task automatic sendChar(input logic [DW:0] c);
    @(negedge clk); charValid = 1; charData = c;
    @(negedge clk); charValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrlState == 3'b000, "R1 ctrl", ctrlState, 0);
    chk(addrIrq == 0, "R1 irq", addrIrq, 0);
    chk(fifoWrite == 0, "R1 write", fifoWrite, 0);
    rstN = 1;
    @(negedge clk);

    // sweep all configs x all characters
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int c = 0; c < 512; c++) begin
        bit md, off0, au, isA, st, irq, off;
        string tag;
        md = cfg[0]; off0 = cfg[1]; au = cfg[2];
        wrCtrl(cfg[2:0]);
        clrIrq();
        isA = md && c[8];
        if (isA && au) begin
          st = (c[7:0] == stationAddr); irq = st; off = !st;
          tag = st ? "R6" : "R7";
        end else if (isA) begin
          st = 1; irq = 1; off = off0; tag = "R4";
        end else begin
          st = !off0; irq = 0; off = off0;
          tag = off0 ? "R3" : (md ? "R5" : (au ? "R10" : "R2"));
        end
        sendChar(c[8:0]);
        chk(fifoWrite == st, {tag, " write"}, fifoWrite, st);
        if (st) chk(fifoData == c[7:0], {tag, " data"}, fifoData, c[7:0]);
        chk(addrIrq == irq, {tag, " irq"}, addrIrq, irq);
        chk(ctrlState == {au, off, md}, {tag, " ctrl"}, ctrlState, {au, off, md});
      end
    end

    // R7 sequence: mismatch, data dropped, match, data stored
    wrCtrl(3'b101); clrIrq();
    sendChar({1'b1, 8'h33});
    chk(ctrlState[1] == 1, "R7 off after miss", ctrlState[1], 1);
    sendChar({1'b0, 8'h11});
    chk(fifoWrite == 0, "R7 data dropped", fifoWrite, 0);
    sendChar({1'b0, 8'h12});
    chk(fifoWrite == 0, "R7 data dropped 2", fifoWrite, 0);
    sendChar({1'b1, 8'h5A});
    chk(fifoWrite == 1 && ctrlState[1] == 0, "R6 match reopens", {fifoWrite, ctrlState[1]}, 2);
    sendChar({1'b0, 8'h44});
    chk(fifoWrite == 1 && fifoData == 8'h44, "R7 data after match", fifoData, 8'h44);

    // R8 sticky and set-wins-over-clear
    repeat (5) @(negedge clk);
    chk(addrIrq == 1, "R8 held", addrIrq, 1);
    @(negedge clk); irqClear = 1; charValid = 1; charData = {1'b1, 8'h5A};
    @(negedge clk); irqClear = 0; charValid = 0;
    chk(addrIrq == 1, "R8 set wins", addrIrq, 1);
    clrIrq();
    chk(addrIrq == 0, "R8 cleared", addrIrq, 0);

    // R9 automatic update beats control write
    @(negedge clk); ctrlWe = 1; ctrlWdata = 3'b101; charValid = 1; charData = {1'b1, 8'h00};
    @(negedge clk); ctrlWe = 0; charValid = 0;
    chk(ctrlState[1] == 1, "R9 miss beats write", ctrlState[1], 1);
    @(negedge clk); ctrlWe = 1; ctrlWdata = 3'b111; charValid = 1; charData = {1'b1, 8'h5A};
    @(negedge clk); ctrlWe = 0; charValid = 0;
    chk(ctrlState[1] == 0, "R9 match beats write", ctrlState[1], 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule